// File: doc/BRIEF.md
# Power-On Request Controller

This always-on controller drives an active-high power-on request to an external power management chip. It runs from a slow always-on clock and watches four inputs: an active-low on/off push button, a wake-up event, a tamper event, and a status flag that reports whether the high-power domain is supplied. All four inputs pass through a two-flop synchronizer. The button is then debounced by a saturating counter. The controller holds one of two states, OFF or ON. It reports the current state on a status output next to the request, and the request comes straight from a flip-flop.

In OFF, any of three sources moves the controller to ON: a qualified button press, a wake-up event, or a tamper event. A wake-up event counts only while the high-power domain is not supplied, because the wake-up timer is gated off whenever that domain has power. In ON, a qualified button press is the only way back to OFF. Software has no path to the request at all.

A build-time parameter picks what the always-on supply's power-on reset (`rstN`) does. In one variant it leaves the request asserted. In the other it leaves the request deasserted.

Top module: `pwr_on_req_ctrl`

## Requirements
- R1: With `PWR_ON_AT_POR` = 0, the controller is in OFF after reset, and both `pwrOnReq` and `stateOn` are 0.
- R2: With `PWR_ON_AT_POR` = 1, the controller is in ON after reset, and both `pwrOnReq` and `stateOn` are 1.
- R3: A button press is qualified when the synchronized `onOffN` is sampled low on `DEBOUNCE_CYCLES` consecutive clock edges (default 24576, which is 750 ms at 32.768 kHz). In OFF, a qualified press sets the state to ON.
- R4: A low run that is even one sample shorter than `DEBOUNCE_CYCLES` has no effect. A single high sample restarts the count from zero, so two short low runs never add up to a press.
- R5: Holding the button low for any length beyond the debounce interval toggles the state only once. The button must be sampled high before another press can be recognised.
- R6: In OFF, a high level on `wakeIn` sets the state to ON while `hpSupplied` is 0.
- R7: While `hpSupplied` is 1, `wakeIn` has no effect and the controller stays in OFF.
- R8: In OFF, a high level on `tamperIn` sets the state to ON, whatever the value of `hpSupplied`.
- R9: In ON, `wakeIn` and `tamperIn` have no effect. A qualified press returns the state to OFF.
- R10: `pwrOnReq` is 1 exactly when `stateOn` is 1. A wake or tamper level first sampled at clock edge k shows on both outputs after edge k+2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on clock |
| rstN | input | 1 | Active-low power-on reset of the always-on supply |
| onOffN | input | 1 | On/off push button, active low, asynchronous |
| wakeIn | input | 1 | Wake-up timer event, level, asynchronous |
| tamperIn | input | 1 | Tamper event, level, asynchronous |
| hpSupplied | input | 1 | High when the high-power domain is supplied |
| pwrOnReq | output | 1 | Power-on request to the power management chip, registered |
| stateOn | output | 1 | Current controller state, 1 means ON |

## Verification
Button low runs of exactly the debounce length and one sample shorter separate a qualified press from a rejected one. Two short runs split by a single high sample show that the count restarts and does not accumulate. Runs far beyond the threshold show the single-toggle rule. Wake pulses are applied with `hpSupplied` both low and high to expose the timer gating. Wake and tamper pulses are also applied in ON, which shows that only the button can turn the controller off. A second instance built with the opposite power-on-reset variant shows the other reset state.

// File: rtl/pwr_on_req_pkg.sv
package pwr_on_req_pkg;

  typedef enum logic {
    ST_OFF = 1'b0,
    ST_ON  = 1'b1
  } pwrState_t;

  // strobes handed from the datapath to the control
  typedef struct packed {
    logic btnPress;
    logic wakeHit;
    logic tampHit;
  } evtStrobes_t;

endpackage

// File: rtl/pwr_sync.sv
module pwr_sync #(
  parameter int              WIDTH     = 4,
  parameter int              STAGES    = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stageQ [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stageQ[i] <= RESET_VAL;
    end else begin
      stageQ[0] <= asyncIn;
      for (int i = 1; i < STAGES; i++) stageQ[i] <= stageQ[i-1];
    end
  end

  assign syncOut = stageQ[STAGES-1];

endmodule

// File: rtl/pwr_on_req_dp.sv
module pwr_on_req_dp
  import pwr_on_req_pkg::*;
#(
  parameter int DEBOUNCE_CYCLES = 24576,
  parameter int SYNC_STAGES     = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        onOffN,
  input  logic        wakeIn,
  input  logic        tamperIn,
  input  logic        hpSupplied,
  output evtStrobes_t evt
);

  localparam int CNT_W = $clog2(DEBOUNCE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(DEBOUNCE_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEBOUNCE_CYCLES - 1);

  logic [3:0] syncVec;
  logic btnSync, wakeSync, tampSync, hpSync;

  // bit order {hp, tamper, wake, button}; the button resets to released
  pwr_sync #(
    .WIDTH    (4),
    .STAGES   (SYNC_STAGES),
    .RESET_VAL(4'b0001)
  ) sync_i (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn({hpSupplied, tamperIn, wakeIn, onOffN}),
    .syncOut(syncVec)
  );

  assign {hpSync, tampSync, wakeSync, btnSync} = syncVec;

  logic [CNT_W-1:0] lowCntQ;
  logic             pressQ;

  // saturating count of consecutive low samples; one pulse per hold
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowCntQ <= '0;
      pressQ  <= 1'b0;
    end else if (btnSync) begin
      lowCntQ <= '0;
      pressQ  <= 1'b0;
    end else begin
      if (lowCntQ != CNT_MAX) lowCntQ <= lowCntQ + 1'b1;
      pressQ <= (lowCntQ == CNT_LAST);
    end
  end

  assign evt.btnPress = pressQ;
  assign evt.wakeHit  = wakeSync & ~hpSync;  // wake timer gated while HP powered
  assign evt.tampHit  = tampSync;

  // R5: a press strobe never lasts two cycles
  assert_press_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    pressQ |=> !pressQ);

  // R3: a press strobe follows a low button sample
  assert_press_after_low_R3: assert property (@(posedge clk) disable iff (!rstN)
    pressQ |-> $past(!btnSync));

endmodule

// File: rtl/pwr_on_req_ctl.sv
module pwr_on_req_ctl
  import pwr_on_req_pkg::*;
#(
  parameter bit PWR_ON_AT_POR = 1'b0
) (
  input  logic        clk,
  input  logic        rstN,
  input  evtStrobes_t evt,
  output logic        pwrOnReq,
  output logic        stateOn
);

  localparam pwrState_t RESET_STATE = PWR_ON_AT_POR ? ST_ON : ST_OFF;

  pwrState_t stateQ, stateNext;
  logic      reqQ;

  always_comb begin
    stateNext = stateQ;
    unique case (stateQ)
      ST_OFF: if (evt.btnPress || evt.wakeHit || evt.tampHit) stateNext = ST_ON;
      ST_ON:  if (evt.btnPress) stateNext = ST_OFF;
      default: stateNext = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= RESET_STATE;
      reqQ   <= PWR_ON_AT_POR;
    end else begin
      stateQ <= stateNext;
      reqQ   <= (stateNext == ST_ON);
    end
  end

  assign pwrOnReq = reqQ;
  assign stateOn  = (stateQ == ST_ON);

  // R9: in ON, only the button leaves the state
  assert_on_holds_R9: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_ON && !evt.btnPress) |=> (stateQ == ST_ON));

  // R7: in OFF, with no enabled source, the state stays OFF
  assert_off_holds_R7: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_OFF && !evt.btnPress && !evt.tampHit && !evt.wakeHit)
      |=> (stateQ == ST_OFF));

endmodule

// File: rtl/pwr_on_req_ctrl.sv
module pwr_on_req_ctrl
  import pwr_on_req_pkg::*;
#(
  parameter int DEBOUNCE_CYCLES = 24576,
  parameter int SYNC_STAGES     = 2,
  parameter bit PWR_ON_AT_POR   = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic onOffN,
  input  logic wakeIn,
  input  logic tamperIn,
  input  logic hpSupplied,
  output logic pwrOnReq,
  output logic stateOn
);

  evtStrobes_t evt;

  pwr_on_req_dp #(
    .DEBOUNCE_CYCLES(DEBOUNCE_CYCLES),
    .SYNC_STAGES    (SYNC_STAGES)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .onOffN    (onOffN),
    .wakeIn    (wakeIn),
    .tamperIn  (tamperIn),
    .hpSupplied(hpSupplied),
    .evt       (evt)
  );

  pwr_on_req_ctl #(
    .PWR_ON_AT_POR(PWR_ON_AT_POR)
  ) ctl_i (
    .clk     (clk),
    .rstN    (rstN),
    .evt     (evt),
    .pwrOnReq(pwrOnReq),
    .stateOn (stateOn)
  );

  // R10: request and status agree
  assert_req_matches_R10: assert property (@(posedge clk) disable iff (!rstN)
    pwrOnReq == stateOn);

endmodule

// File: tb/pwr_on_req_ctrl_tb.sv
module pwr_on_req_ctrl_tb_top;

  localparam int DEB = 8;

  typedef struct packed {
    logic [1:0] kind;    // 0 press, 1 wake, 2 tamper
    logic [7:0] lowLen;  // press length in samples
    logic       hp;      // hpSupplied during the event
    logic       expReq;  // expected request afterwards
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 8'd7,  1'b0, 1'b0},  // R4 one short
    '{2'd0, 8'd8,  1'b0, 1'b1},  // R3 exact length
    '{2'd1, 8'd0,  1'b0, 1'b1},  // R9 wake ignored in ON
    '{2'd2, 8'd0,  1'b0, 1'b1},  // R9 tamper ignored in ON
    '{2'd0, 8'd20, 1'b0, 1'b0},  // R9 press to OFF, R5 one toggle
    '{2'd1, 8'd0,  1'b1, 1'b0},  // R7 wake gated
    '{2'd1, 8'd0,  1'b0, 1'b1},  // R6 wake powers on
    '{2'd0, 8'd8,  1'b0, 1'b0},  // R9 back off
    '{2'd2, 8'd0,  1'b1, 1'b1},  // R8 tamper with hp
    '{2'd0, 8'd8,  1'b0, 1'b0}   // R9 back off
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic onOffN = 1'b1, wakeIn = 1'b0, tamperIn = 1'b0, hpSupplied = 1'b0;
  logic pwrOnReq, stateOn, porReq, porState;
  int   total = 0, bad = 0;

  always #2 clk = ~clk;

  pwr_on_req_ctrl #(.DEBOUNCE_CYCLES(DEB), .PWR_ON_AT_POR(1'b0)) dut_i (
    .clk(clk), .rstN(rstN), .onOffN(onOffN), .wakeIn(wakeIn),
    .tamperIn(tamperIn), .hpSupplied(hpSupplied),
    .pwrOnReq(pwrOnReq), .stateOn(stateOn));

  pwr_on_req_ctrl #(.DEBOUNCE_CYCLES(DEB), .PWR_ON_AT_POR(1'b1)) dut_por_i (
    .clk(clk), .rstN(rstN), .onOffN(onOffN), .wakeIn(wakeIn),
    .tamperIn(tamperIn), .hpSupplied(hpSupplied),
    .pwrOnReq(porReq), .stateOn(porState));

  task automatic check(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic press(input int len);
    @(negedge clk) onOffN = 1'b0;
    repeat (len) @(negedge clk);
    onOffN = 1'b1;
    idle(6);
  endtask

  task automatic pulse(input logic isTamper, input logic hp);
    @(negedge clk) hpSupplied = hp;
    idle(4);
    if (isTamper) tamperIn = 1'b1; else wakeIn = 1'b1;
    idle(4);
    tamperIn = 1'b0;
    wakeIn   = 1'b0;
    idle(6);
    hpSupplied = 1'b0;
    idle(4);
  endtask

  initial begin
    idle(3);
    check("R1 req after reset", pwrOnReq, 1'b0);
    check("R1 state after reset", stateOn, 1'b0);
    check("R2 por variant req", porReq, 1'b1);
    check("R2 por variant state", porState, 1'b1);
    @(negedge clk) rstN = 1'b1;
    idle(4);
    check("R1 req idle", pwrOnReq, 1'b0);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].kind == 2'd0) press(int'(VECS[i].lowLen));
      else pulse(VECS[i].kind == 2'd2, VECS[i].hp);
      check($sformatf("vector %0d req (R3/R4/R5/R6/R7/R8/R9)", i), pwrOnReq, VECS[i].expReq);
      check($sformatf("vector %0d state R10", i), stateOn, VECS[i].expReq);
    end

    // R4: two short runs split by one high sample do not add up
    @(negedge clk) onOffN = 1'b0;
    idle(5);
    onOffN = 1'b1;
    idle(1);
    onOffN = 1'b0;
    idle(5);
    onOffN = 1'b1;
    idle(6);
    check("R4 split runs ignored", pwrOnReq, 1'b0);

    // R5: very long hold from OFF toggles once
    press(40);
    check("R5 long hold single toggle", pwrOnReq, 1'b1);

    // R10: wake latency in OFF
    press(DEB);
    check("R9 off before latency test", pwrOnReq, 1'b0);
    @(negedge clk) wakeIn = 1'b1;  // first sampled at next edge k
    @(negedge clk);                // after k
    @(negedge clk);                // after k+1
    check("R10 not yet after k+1", pwrOnReq, 1'b0);
    @(negedge clk);                // after k+2
    check("R10 req after k+2", pwrOnReq, 1'b1);
    check("R10 state after k+2", stateOn, 1'b1);
    wakeIn = 1'b0;
    idle(4);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule